// File: doc/BRIEF.md
# SMBus Host Transaction Controller

This block is the host side of a system management bus. A processor programs it through a byte-wide register window that spans 32 offsets. Software first loads the target address together with a direction bit, a command byte and up to two data bytes. It then writes a start command that carries a protocol size code. From that point the controller runs the whole transaction by itself: quick, send/receive byte, read/write byte data, read/write word data, or process call. It drives a byte-level bus engine with four operations (start with address byte, write byte, read byte, stop) and reads back the engine's per-operation result.

Progress is visible in two places. Busy indication appears in the control register and in status bit 0. The outcome (done, device error, collision) is kept in sticky status bits that software clears by writing ones. A kill command returns the controller to idle at any time. Bit-level bus timing is left to the engine.

Top module: `smbus_host_ctrl`

## Requirements
- R1: After reset the status, control, enable, address, command and data registers read 0x00 and no engine request is issued.
- R2: Writing host control (offset 0x03) with bit 4 set, bit 5 clear and a size code 0..4 in bits [2:0] starts a transaction. While it runs, control (offset 0x02) bits [1:0] read 01 and status (offset 0x00) bit 0 reads 1. Both read 0 once the controller is idle again.
- R3: A start write carrying a size code of 5, 6 or 7 is ignored: no busy indication and no engine request.
- R4: Engine operations use the codes 0=start+address byte, 1=write byte, 2=read byte, 3=stop. The address register (offset 0x04) holds the 7-bit address in bits [7:1] and the direction in bit 0 (1=read). The sequences are:
  - size 0: start(addr as written), stop.
  - size 1 write: start(addr), write(command, offset 0x05), stop. Size 1 read: start(addr), read, stop.
  - size 2 / size 3 write: start(addr with bit0=0), write(command), write(data low, offset 0x08), then write(data high, offset 0x09) for size 3 only, then stop.
  - size 2 / size 3 read: start(addr with bit0=0), write(command), start(addr with bit0=1), one read (size 2) or two reads (size 3), stop.
  - size 4: start(bit0=0), write(command), write(low), write(high), start(bit0=1), read, read, stop. The direction bit is ignored.
- R5: The last read of a transaction is flagged for NACK and every earlier read for ACK. The first read byte is stored in data low and the second in data high.
- R6: A NACK reported for a start or write operation makes the next engine operation a stop. The device error flag (status bit 1) sets at once, and done (status bit 3) sets when the stop completes.
- R7: Lost arbitration on any operation sets collision (status bit 2) and done. The controller goes idle without issuing a stop.
- R8: Status bits 1..3 are sticky. Writing 1 to a bit clears it and writing 0 leaves it. A hardware set in the same cycle as a clear leaves the bit set.
- R9: Writing host control with bit 5 set returns the controller to idle on the next cycle without setting any status bit. It wins over a start bit written in the same byte, and an engine result arriving after the kill is ignored.
- R10: While busy, writes to the address, command, data low and data high registers are ignored.
- R11: Only one engine operation is outstanding at a time: a new request follows only the result of the previous one.
- R12: A start write while busy is ignored. The running transaction continues unchanged.
- R13: The enable register (offset 0x01) and control bits [7:2] store and read back whatever software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW | Register offset for read and write |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| eng_req | output | 1 | One-cycle request for an engine operation |
| eng_op | output | 2 | Operation code (0 start, 1 write, 2 read, 3 stop) |
| eng_byte | output | 8 | Address or data byte for start/write |
| eng_last | output | 1 | Read is the last byte (NACK it) |
| eng_done | input | 1 | Engine finished the outstanding operation |
| eng_nack | input | 1 | With eng_done: target did not acknowledge |
| eng_lost | input | 1 | With eng_done: arbitration lost |
| eng_rbyte | input | 8 | With eng_done: byte received by a read |

## Verification
Two events can meet in one clock: the sequencer raising a status flag and software writing ones to clear the status register. The bench provokes the overlap by holding back the engine's stop completion, then releasing it in the very cycle that a clear write for both the device-error and done bits is presented. The read that follows must show done still set and the older device-error bit gone, which shows that the set wins only for the bit it touches.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

    localparam int DW = 8;

    // register offsets within the window
    localparam int OFS_STATUS  = 'h00;
    localparam int OFS_ENABLE  = 'h01;
    localparam int OFS_CTRL    = 'h02;
    localparam int OFS_HOSTCTL = 'h03;
    localparam int OFS_ADDR    = 'h04;
    localparam int OFS_CMD     = 'h05;
    localparam int OFS_DLO     = 'h08;
    localparam int OFS_DHI     = 'h09;

    // host control bits
    localparam int HC_GO_BIT   = 4;
    localparam int HC_KILL_BIT = 5;

    // status bits
    localparam int ST_BUSY_BIT = 0;
    localparam int ST_DERR_BIT = 1;
    localparam int ST_COLL_BIT = 2;
    localparam int ST_DONE_BIT = 3;

    typedef enum logic [2:0] {
        SZ_QUICK = 3'd0,
        SZ_BYTE  = 3'd1,
        SZ_BDATA = 3'd2,
        SZ_WORD  = 3'd3,
        SZ_PCALL = 3'd4
    } size_e;

    localparam logic [2:0] SZ_LAST = 3'(SZ_PCALL);

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } eng_op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_WLO,
        PH_WHI,
        PH_RSTART,
        PH_RLO,
        PH_RHI,
        PH_STOP
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        logic       waiting;
        logic [2:0] size;
    } seq_state_t;

    typedef struct packed {
        logic done;
        logic coll;
        logic derr;
    } st_flags_t;

    typedef struct packed {
        logic [DW-1:0] enable;
        logic [5:0]    ctrl_hi;
        logic [DW-1:0] slave;
        logic [DW-1:0] cmd;
        logic [DW-1:0] dlo;
        logic [DW-1:0] dhi;
    } regs_t;

endpackage

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbus_host_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [DW-1:0] ld_byte,
    output regs_t         regs_o,
    output logic          start_o,
    output logic [2:0]    start_size_o,
    output logic          kill_o
);

    localparam logic [AW-1:0] A_ENABLE  = AW'(OFS_ENABLE);
    localparam logic [AW-1:0] A_CTRL    = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_HOSTCTL = AW'(OFS_HOSTCTL);
    localparam logic [AW-1:0] A_ADDR    = AW'(OFS_ADDR);
    localparam logic [AW-1:0] A_CMD     = AW'(OFS_CMD);
    localparam logic [AW-1:0] A_DLO     = AW'(OFS_DLO);
    localparam logic [AW-1:0] A_DHI     = AW'(OFS_DHI);

    regs_t regs_d, regs_q;
    logic  hit_hc;
    logic  sw_ok;

    always_comb begin
        hit_hc       = wr_en && (wr_addr == A_HOSTCTL);
        kill_o       = hit_hc && wr_data[HC_KILL_BIT];
        start_o      = hit_hc && wr_data[HC_GO_BIT] && !wr_data[HC_KILL_BIT]
                       && !busy && (wr_data[2:0] <= SZ_LAST);
        start_size_o = wr_data[2:0];
        // transaction parameters are frozen while the sequencer owns them
        sw_ok        = wr_en && !busy;

        regs_d = regs_q;
        if (wr_en && wr_addr == A_ENABLE) regs_d.enable  = wr_data;
        if (wr_en && wr_addr == A_CTRL)   regs_d.ctrl_hi = wr_data[7:2];
        if (sw_ok && wr_addr == A_ADDR)   regs_d.slave   = wr_data;
        if (sw_ok && wr_addr == A_CMD)    regs_d.cmd     = wr_data;
        if (sw_ok && wr_addr == A_DLO)    regs_d.dlo     = wr_data;
        if (sw_ok && wr_addr == A_DHI)    regs_d.dhi     = wr_data;
        if (ld_lo)                        regs_d.dlo     = ld_byte;
        if (ld_hi)                        regs_d.dhi     = ld_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/smbus_host_status.sv
module smbus_host_status
    import smbus_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_we,
    input  logic [DW-1:0] clr_mask,
    input  st_flags_t     set_evt,
    output st_flags_t     flags_o
);

    st_flags_t flags_d, flags_q;
    st_flags_t clr;

    always_comb begin
        clr.done = clr_we && clr_mask[ST_DONE_BIT];
        clr.coll = clr_we && clr_mask[ST_COLL_BIT];
        clr.derr = clr_we && clr_mask[ST_DERR_BIT];
        // a hardware event in the same cycle as a clear keeps the bit set
        flags_d = (flags_q & ~clr) | set_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq
    import smbus_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    start_size,
    input  logic          kill,
    input  logic [DW-1:0] slave,
    input  logic [DW-1:0] cmd,
    input  logic [DW-1:0] dlo,
    input  logic [DW-1:0] dhi,
    input  logic          eng_done,
    input  logic          eng_nack,
    input  logic          eng_lost,
    output logic          busy,
    output logic          eng_req,
    output eng_op_e       eng_op,
    output logic [DW-1:0] eng_byte,
    output logic          eng_last,
    output logic          ld_lo,
    output logic          ld_hi,
    output st_flags_t     evt
);

    seq_state_t q, d;
    logic       rd_dir;
    logic       two_reads;

    function automatic phase_e next_phase(input phase_e ph, input logic [2:0] sz,
                                          input logic dir);
        phase_e nx;
        nx = PH_STOP;
        unique case (ph)
            PH_ADDR: begin
                if (sz == SZ_QUICK)                nx = PH_STOP;
                else if (sz == SZ_BYTE && dir)     nx = PH_RLO;
                else                               nx = PH_CMD;
            end
            PH_CMD: begin
                if (sz == SZ_BYTE)                 nx = PH_STOP;
                else if (sz == SZ_PCALL)           nx = PH_WLO;
                else if (dir)                      nx = PH_RSTART;
                else                               nx = PH_WLO;
            end
            PH_WLO:    nx = (sz == SZ_BDATA) ? PH_STOP : PH_WHI;
            PH_WHI:    nx = (sz == SZ_PCALL) ? PH_RSTART : PH_STOP;
            PH_RSTART: nx = PH_RLO;
            PH_RLO:    nx = (sz == SZ_WORD || sz == SZ_PCALL) ? PH_RHI : PH_STOP;
            default:   nx = PH_STOP;
        endcase
        return nx;
    endfunction

    always_comb begin
        rd_dir    = slave[0];
        two_reads = (q.size == SZ_WORD) || (q.size == SZ_PCALL);

        // operation presented for the current phase
        eng_op   = OP_STOP;
        eng_byte = '0;
        eng_last = 1'b0;
        unique case (q.phase)
            PH_ADDR: begin
                eng_op   = OP_START;
                eng_byte = (q.size == SZ_QUICK || q.size == SZ_BYTE)
                           ? slave : {slave[7:1], 1'b0};
            end
            PH_RSTART: begin
                eng_op   = OP_START;
                eng_byte = {slave[7:1], 1'b1};
            end
            PH_CMD: begin eng_op = OP_WRITE; eng_byte = cmd; end
            PH_WLO: begin eng_op = OP_WRITE; eng_byte = dlo; end
            PH_WHI: begin eng_op = OP_WRITE; eng_byte = dhi; end
            PH_RLO: begin eng_op = OP_READ;  eng_last = !two_reads; end
            PH_RHI: begin eng_op = OP_READ;  eng_last = 1'b1; end
            default: eng_op = OP_STOP;
        endcase

        d       = q;
        eng_req = 1'b0;
        ld_lo   = 1'b0;
        ld_hi   = 1'b0;
        evt     = '0;

        if (q.phase != PH_IDLE && !q.waiting) begin
            eng_req   = 1'b1;
            d.waiting = 1'b1;
        end

        if (q.phase == PH_IDLE) begin
            if (start) begin
                d.phase   = PH_ADDR;
                d.size    = start_size;
                d.waiting = 1'b0;
            end
        end else if (q.waiting && eng_done) begin
            d.waiting = 1'b0;
            if (eng_lost) begin
                evt.coll = 1'b1;
                evt.done = 1'b1;
                d.phase  = PH_IDLE;
            end else if (q.phase == PH_STOP) begin
                evt.done = 1'b1;
                d.phase  = PH_IDLE;
            end else if (eng_nack && eng_op != OP_READ) begin
                evt.derr = 1'b1;
                d.phase  = PH_STOP;
            end else begin
                ld_lo   = (q.phase == PH_RLO);
                ld_hi   = (q.phase == PH_RHI);
                d.phase = next_phase(q.phase, q.size, rd_dir);
            end
        end

        if (kill) begin
            d.phase   = PH_IDLE;
            d.waiting = 1'b0;
            evt       = '0;
            ld_lo     = 1'b0;
            ld_hi     = 1'b0;
        end

        busy = (q.phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase   <= PH_IDLE;
            q.waiting <= 1'b0;
            q.size    <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl
    import smbus_host_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr_en,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          eng_req,
    output logic [1:0]    eng_op,
    output logic [7:0]    eng_byte,
    output logic          eng_last,
    input  logic          eng_done,
    input  logic          eng_nack,
    input  logic          eng_lost,
    input  logic [7:0]    eng_rbyte
);

    regs_t         regs;
    logic          start_go;
    logic [2:0]    start_size;
    logic          kill;
    logic          seq_busy;
    logic          ld_lo;
    logic          ld_hi;
    st_flags_t     evt;
    st_flags_t     st_flags;
    eng_op_e       seq_op;
    logic [DW-1:0] status_byte;
    logic [DW-1:0] ctrl_byte;
    logic          st_clr_we;

    smbus_host_regs #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr_en),
        .wr_addr      (reg_addr),
        .wr_data      (reg_wdata),
        .busy         (seq_busy),
        .ld_lo        (ld_lo),
        .ld_hi        (ld_hi),
        .ld_byte      (eng_rbyte),
        .regs_o       (regs),
        .start_o      (start_go),
        .start_size_o (start_size),
        .kill_o       (kill)
    );

    smbus_host_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_go),
        .start_size (start_size),
        .kill       (kill),
        .slave      (regs.slave),
        .cmd        (regs.cmd),
        .dlo        (regs.dlo),
        .dhi        (regs.dhi),
        .eng_done   (eng_done),
        .eng_nack   (eng_nack),
        .eng_lost   (eng_lost),
        .busy       (seq_busy),
        .eng_req    (eng_req),
        .eng_op     (seq_op),
        .eng_byte   (eng_byte),
        .eng_last   (eng_last),
        .ld_lo      (ld_lo),
        .ld_hi      (ld_hi),
        .evt        (evt)
    );

    assign st_clr_we = reg_wr_en && (reg_addr == AW'(OFS_STATUS));

    smbus_host_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (st_clr_we),
        .clr_mask (reg_wdata),
        .set_evt  (evt),
        .flags_o  (st_flags)
    );

    assign eng_op = seq_op;

    always_comb begin
        status_byte = '0;
        status_byte[ST_BUSY_BIT] = seq_busy;
        status_byte[ST_DERR_BIT] = st_flags.derr;
        status_byte[ST_COLL_BIT] = st_flags.coll;
        status_byte[ST_DONE_BIT] = st_flags.done;
        ctrl_byte = {regs.ctrl_hi, 1'b0, seq_busy};

        unique case (reg_addr)
            AW'(OFS_STATUS): reg_rdata = status_byte;
            AW'(OFS_ENABLE): reg_rdata = regs.enable;
            AW'(OFS_CTRL):   reg_rdata = ctrl_byte;
            AW'(OFS_ADDR):   reg_rdata = regs.slave;
            AW'(OFS_CMD):    reg_rdata = regs.cmd;
            AW'(OFS_DLO):    reg_rdata = regs.dlo;
            AW'(OFS_DHI):    reg_rdata = regs.dhi;
            default:         reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk
    import smbus_host_pkg::*;
#(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr_en,
    input logic [7:0]    reg_wdata,
    input logic          busy,
    input logic          eng_req,
    input logic [1:0]    eng_op,
    input logic          eng_done,
    input logic          eng_nack,
    input logic          eng_lost,
    input logic          st_done,
    input logic          st_coll,
    input logic [7:0]    slave
);

    logic       pend_q;
    logic [1:0] last_op_q;
    logic       kill_wr;
    logic       hc_wr;
    logic       st_wr;

    assign hc_wr   = reg_wr_en && (reg_addr == AW'(OFS_HOSTCTL));
    assign kill_wr = hc_wr && reg_wdata[HC_KILL_BIT];
    assign st_wr   = reg_wr_en && (reg_addr == AW'(OFS_STATUS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            last_op_q <= 2'(OP_STOP);
        end else begin
            if (kill_wr)       pend_q <= 1'b0;
            else if (eng_req)  pend_q <= 1'b1;
            else if (eng_done) pend_q <= 1'b0;
            if (eng_req) last_op_q <= eng_op;
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !pend_q); // R11

    AST_KILL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        kill_wr |=> !busy); // R9

    AST_RESERVED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hc_wr && reg_wdata[HC_GO_BIT] && reg_wdata[2:0] > SZ_LAST) |=> !busy); // R3

    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en && reg_addr == AW'(OFS_ADDR)) |=> $stable(slave)); // R10

    AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pend_q && eng_done && eng_nack && !eng_lost && !kill_wr
         && (last_op_q == 2'(OP_START) || last_op_q == 2'(OP_WRITE)))
        |=> (eng_req && eng_op == 2'(OP_STOP))); // R6

    AST_LOST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pend_q && eng_done && eng_lost && !kill_wr)
        |=> (!busy && st_coll && st_done)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !(st_wr && reg_wdata[ST_DONE_BIT])) |=> st_done); // R8

endmodule

bind smbus_host_ctrl smbus_host_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .busy      (seq_busy),
    .eng_req   (eng_req),
    .eng_op    (eng_op),
    .eng_done  (eng_done),
    .eng_nack  (eng_nack),
    .eng_lost  (eng_lost),
    .st_done   (status_byte[3]),
    .st_coll   (status_byte[2]),
    .slave     (regs.slave)
);

// File: tb/smbus_host_ctrl_tb.sv
module smbus_host_ctrl_tb;
    import smbus_host_pkg::*;

    localparam int AW = 5;
    localparam logic [AW-1:0] A_ST = 5'h00, A_EN = 5'h01, A_CT = 5'h02, A_HC = 5'h03,
                              A_AD = 5'h04, A_CM = 5'h05, A_LO = 5'h08, A_HI = 5'h09;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          eng_req;
    logic [1:0]    eng_op;
    logic [7:0]    eng_byte;
    logic          eng_last;
    logic          eng_done, eng_nack, eng_lost;
    logic [7:0]    eng_rbyte;

    always #10 clk = ~clk;

    // ---------------- engine model ----------------
    logic       mdl_done = 1'b0, mdl_nack = 1'b0, mdl_lost = 1'b0;
    logic [7:0] mdl_rbyte = '0;
    logic       mpend = 1'b0;
    logic       force_done = 1'b0;
    logic       log_clr = 1'b0;
    logic       hold_stop = 1'b0;
    int         cnt = 0, ln = 0, rdn = 0, overlaps = 0;
    int         nack_at = -1, lost_at = -1;
    logic [1:0] lop [16];
    logic [7:0] lbyte [16];
    logic       llast [16];

    always @(posedge clk) begin
        mdl_done <= 1'b0;
        if (log_clr) begin
            ln  <= 0;
            rdn <= 0;
        end else if (eng_req) begin
            if (mpend) overlaps <= overlaps + 1;
            if (ln < 16) begin
                lop[ln]   <= eng_op;
                lbyte[ln] <= eng_byte;
                llast[ln] <= eng_last;
            end
            ln        <= ln + 1;
            mdl_nack  <= (ln == nack_at);
            mdl_lost  <= (ln == lost_at);
            mdl_rbyte <= (rdn == 0) ? 8'h9A : 8'hBC;
            if (eng_op == OP_READ) rdn <= rdn + 1;
            mpend <= 1'b1;
            cnt   <= (hold_stop && eng_op == OP_STOP) ? 0 : 2;
        end
        if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                mdl_done <= 1'b1;
                mpend    <= 1'b0;
            end
        end
        if (force_done) mpend <= 1'b0;
    end

    assign eng_done  = mdl_done | force_done;
    assign eng_nack  = mdl_done & mdl_nack;
    assign eng_lost  = mdl_done & mdl_lost;
    assign eng_rbyte = mdl_rbyte;

    smbus_host_ctrl #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_req(eng_req),
        .eng_op(eng_op), .eng_byte(eng_byte), .eng_last(eng_last),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_lost(eng_lost),
        .eng_rbyte(eng_rbyte)
    );

    // ---------------- checking helpers ----------------
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic clr_log();
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int g = 0; g < 300; g++) begin
            rd(A_CT, v);
            if (v[1:0] == 2'b00) break;
        end
    endtask

    task automatic setup(input logic [7:0] a);
        wr(A_ST, 8'h0e);
        clr_log();
        wr(A_AD, a);
        wr(A_CM, 8'h3C);
        wr(A_LO, 8'h11);
        wr(A_HI, 8'h22);
    endtask

    function automatic logic [10:0] st(input logic [1:0] o, input logic l, input logic [7:0] b);
        return {o, l, b};
    endfunction

    // row: size[3] dir[1] n[4] explo[8] exphi[8] then 8 steps of {op,last,byte}, step0 first
    localparam logic [111:0] VEC [8] = '{
        {3'd0, 1'b0, 4'd2, 8'h11, 8'h22, st(OP_START,0,8'hA0), st(OP_STOP,0,8'h00), 66'd0},
        {3'd1, 1'b1, 4'd3, 8'h9A, 8'h22, st(OP_START,0,8'hA1), st(OP_READ,1,8'h00),
                                          st(OP_STOP,0,8'h00), 55'd0},
        {3'd1, 1'b0, 4'd3, 8'h11, 8'h22, st(OP_START,0,8'hA0), st(OP_WRITE,0,8'h3C),
                                          st(OP_STOP,0,8'h00), 55'd0},
        {3'd2, 1'b1, 4'd5, 8'h9A, 8'h22, st(OP_START,0,8'hA0), st(OP_WRITE,0,8'h3C),
                                          st(OP_START,0,8'hA1), st(OP_READ,1,8'h00),
                                          st(OP_STOP,0,8'h00), 33'd0},
        {3'd2, 1'b0, 4'd4, 8'h11, 8'h22, st(OP_START,0,8'hA0), st(OP_WRITE,0,8'h3C),
                                          st(OP_WRITE,0,8'h11), st(OP_STOP,0,8'h00), 44'd0},
        {3'd3, 1'b0, 4'd5, 8'h11, 8'h22, st(OP_START,0,8'hA0), st(OP_WRITE,0,8'h3C),
                                          st(OP_WRITE,0,8'h11), st(OP_WRITE,0,8'h22),
                                          st(OP_STOP,0,8'h00), 33'd0},
        {3'd3, 1'b1, 4'd6, 8'h9A, 8'hBC, st(OP_START,0,8'hA0), st(OP_WRITE,0,8'h3C),
                                          st(OP_START,0,8'hA1), st(OP_READ,0,8'h00),
                                          st(OP_READ,1,8'h00), st(OP_STOP,0,8'h00), 22'd0},
        {3'd4, 1'b1, 4'd8, 8'h9A, 8'hBC, st(OP_START,0,8'hA0), st(OP_WRITE,0,8'h3C),
                                          st(OP_WRITE,0,8'h11), st(OP_WRITE,0,8'h22),
                                          st(OP_START,0,8'hA1), st(OP_READ,0,8'h00),
                                          st(OP_READ,1,8'h00), st(OP_STOP,0,8'h00)}
    };

    // compare the logged engine operations against a row; returns mismatch count
    function automatic int seq_mismatch(input logic [111:0] row);
        int bad = 0;
        int n = int'(row[107:104]);
        if (ln != n) bad++;
        for (int i = 0; i < n && i < 16; i++) begin
            logic [10:0] s = row[87 - 11*i -: 11];
            if (lop[i] !== s[10:9] || llast[i] !== s[8]) bad++;
            if ((s[10:9] == OP_START || s[10:9] == OP_WRITE) && lbyte[i] !== s[7:0]) bad++;
        end
        return bad;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_ST, v); chk("R1 status", v, 8'h00);
        rd(A_CT, v); chk("R1 control", v, 8'h00);
        rd(A_AD, v); chk("R1 address", v, 8'h00);
        rd(A_EN, v); chk("R1 enable", v, 8'h00);
        chk("R1 no request", eng_req, 0);

        // R13 plain storage
        wr(A_EN, 8'h5A); rd(A_EN, v); chk("R13 enable", v, 8'h5A);
        wr(A_CT, 8'hA4); rd(A_CT, v); chk("R13 control hi", v, 8'hA4);
        wr(A_CT, 8'h00);

        // table of protocol sequences: R2 R4 R5
        for (int r = 0; r < 8; r++) begin
            logic [111:0] row = VEC[r];
            setup(row[108] ? 8'hA1 : 8'hA0);
            wr(A_HC, {5'b00010, row[111:109]});
            rd(A_CT, v); chk($sformatf("R2 busy bits row %0d", r), v, 8'h01);
            rd(A_ST, v); chk($sformatf("R2 status busy row %0d", r), v[0], 1);
            wait_idle();
            chk($sformatf("R4 sequence row %0d", r), seq_mismatch(row), 0);
            rd(A_LO, v); chk($sformatf("R5 data low row %0d", r), v, row[103:96]);
            rd(A_HI, v); chk($sformatf("R5 data high row %0d", r), v, row[95:88]);
            rd(A_ST, v); chk($sformatf("R2 done idle row %0d", r), v, 8'h08);
        end

        // R3 reserved size codes
        for (int c = 5; c < 8; c++) begin
            setup(8'hA0);
            wr(A_HC, 8'h10 | 8'(c));
            repeat (4) @(negedge clk);
            rd(A_CT, v); chk($sformatf("R3 size %0d busy", c), v, 8'h00);
            chk($sformatf("R3 size %0d requests", c), ln, 0);
        end

        // R10 R12 writes and restart while busy
        setup(8'hA0);
        wr(A_HC, 8'h13);
        wr(A_AD, 8'h55);
        wr(A_CM, 8'h77);
        wr(A_LO, 8'h33);
        wr(A_HI, 8'h44);
        wr(A_HC, 8'h10);
        wait_idle();
        rd(A_AD, v); chk("R10 address kept", v, 8'hA0);
        rd(A_CM, v); chk("R10 command kept", v, 8'h3C);
        rd(A_LO, v); chk("R10 data low kept", v, 8'h11);
        rd(A_HI, v); chk("R10 data high kept", v, 8'h22);
        chk("R12 restart ignored", seq_mismatch(VEC[5]), 0);

        // R6 NACK on the command byte of a byte-data write
        setup(8'hA0);
        nack_at = 1;
        wr(A_HC, 8'h12);
        wait_idle();
        nack_at = -1;
        chk("R6 op count", ln, 3);
        chk("R6 stop follows nack", lop[2], OP_STOP);
        rd(A_ST, v); chk("R6 status", v, 8'h0a);

        // R6 NACK on the address of a quick command; status left set
        setup(8'hA0);
        nack_at = 0;
        wr(A_HC, 8'h10);
        wait_idle();
        nack_at = -1;
        chk("R6 quick op count", ln, 2);
        rd(A_ST, v); chk("R6 quick status", v, 8'h0a);

        // R8 writing zero keeps sticky bits
        wr(A_ST, 8'h00);
        rd(A_ST, v); chk("R8 zero write", v, 8'h0a);

        // R8 hardware set and software clear in the same cycle
        clr_log();
        hold_stop = 1'b1;
        wr(A_HC, 8'h10);
        for (int g = 0; g < 50 && ln < 2; g++) @(negedge clk);
        @(negedge clk);
        force_done = 1'b1;
        reg_addr = A_ST; reg_wdata = 8'h0a; reg_wr_en = 1'b1;
        @(negedge clk);
        force_done = 1'b0; reg_wr_en = 1'b0;
        hold_stop = 1'b0;
        rd(A_ST, v); chk("R8 set wins, other bit cleared", v, 8'h08);
        wr(A_ST, 8'h08);
        rd(A_ST, v); chk("R8 one clears", v, 8'h00);

        // R7 lost arbitration on the command byte
        setup(8'hA0);
        lost_at = 1;
        wr(A_HC, 8'h13);
        wait_idle();
        lost_at = -1;
        chk("R7 op count no stop", ln, 2);
        rd(A_ST, v); chk("R7 status", v, 8'h0c);

        // R9 kill mid-transaction
        setup(8'hA1);
        wr(A_HC, 8'h13);
        repeat (3) @(negedge clk);
        wr(A_HC, 8'h20);
        rd(A_CT, v); chk("R9 idle after kill", v, 8'h00);
        rd(A_ST, v); chk("R9 no status", v, 8'h00);
        repeat (10) @(negedge clk);
        rd(A_ST, v); chk("R9 late result ignored", v, 8'h00);
        clr_log();
        wr(A_HC, 8'h30);
        repeat (3) @(negedge clk);
        rd(A_CT, v); chk("R9 kill beats start", v, 8'h00);
        chk("R9 no request", ln, 0);

        // R11 single outstanding request
        chk("R11 overlapping requests", overlaps, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule